// File: doc/BRIEF.md
# Page-Mode Pseudo-Static Memory Controller

This block sits between an on-chip requester and an external pseudo-static memory that presents an asynchronous SRAM-style pin set. It turns single read and write requests into the active-low chip select, output enable, write strobe and two byte-lane enables. It drives a 22-bit word address and shares a 16-bit bidirectional data bus with the memory. Every analogue limit is given in nanoseconds and turned into a clock count by rounding up against the clock-period parameter. All pin pulses are therefore whole cycles that meet or exceed those limits.

Reads that stay inside one 8-word page take a fast path. The chip stays selected, only the three low address bits move, and each extra word costs the short page cycle rather than the full random cycle. The burst closes on its own before the selected time limit runs out. It also closes when the next request is a write, falls in another page, or is not present. Requests use a valid/ready handshake. Read data returns with a one-cycle response strobe, and unselected byte lanes read as zero.

Top module: `psram_page_ctrl`

## Requirements
- R1: While reset is high and after it is released with no request, chip select, output enable, write strobe and both lane enables stay high and the response strobe stays low.
- R2: A read that starts from the deselected state holds chip select and output enable low for RC cycles, where RC is 65 ns rounded up to clock periods (7 at 10 ns). Its data appears on the response with the strobe exactly RC cycles after the accepting edge. The strobe lasts one cycle.
- R3: A read to the same page (equal address bits 21:3) offered in the cycle after a response is accepted without chip select rising. Only the low address bits change. Its data returns PRC cycles after acceptance, where PRC is 20 ns rounded up (2).
- R4: A read to another page, a write, or no request in that cycle closes the burst. Chip select rises, and the next read pays the full RC latency.
- R5: Chip select never stays low for 4000 ns (400 cycles) or more. Page requests are refused, and the burst closes, before that limit.
- R6: Host lane enable bit 0 selects data bits 7:0 (lower enable pin), bit 1 selects bits 15:8 (upper enable pin), and the value 00 selects both. Writes change only the selected lanes, and reads return zero in unselected lanes.
- R7: A write holds the write strobe low for at least 40 ns (4 cycles) with output enable high. The write data is on the bus throughout and is driven one more cycle after the strobe rises. The bus is never driven while output enable is low.
- R8: Chip select stays high for at least 12 ns (2 cycles) between any two accesses.
- R9: At least 25 ns (3 cycles) pass between the write strobe rising and output enable falling.
- R10: Chip selected with output disabled never lasts 1000 ns (100 cycles).
- R11: A request is taken only on a clock edge where valid and ready are both high, and ready is low while a write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge when valid is high |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 22 | Word address |
| req_be | input | 2 | Active-high lane enables, 00 means both |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_addr | output | 22 | Memory address |
| mem_dq | inout | 16 | Shared data bus |

## Verification
The assertions assume that the memory drives the bus only while it is selected with output enable low. They also assume that it returns valid data once the rounded access counts have passed, so the bus-ownership and latency checks depend on a well-behaved memory. The bench memory model meets this by driving the bus only in that window. It presents a poison word until the random or page access time has elapsed since the last address or select change, so a controller that samples early reads the wrong value. The model commits a write only when the strobe was low for the full pulse width.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int ADDR_W    = 22;
    localparam int DATA_W    = 16;
    localparam int LANE_W    = DATA_W / 2;
    localparam int PAGE_BITS = 3;
    localparam int TAG_W     = ADDR_W - PAGE_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_OPEN,
        ST_RD_PAGE,
        ST_WR_PULSE,
        ST_WR_HOLD
    } pstate_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        be;
        logic [DATA_W-1:0] wdata;
    } preq_t;

    // Round a nanosecond limit up to whole clock periods.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Byte-lane mask; an all-zero enable selects the full word.
    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] be);
        logic all;
        all = (be == 2'b00);
        return {{LANE_W{be[1] | all}}, {LANE_W{be[0] | all}}};
    endfunction

endpackage

// File: rtl/psram_gap_tracker.sv
module psram_gap_tracker #(
    parameter int CP_CYC   = 2,
    parameter int WHOL_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic deselected,
    input  logic strobe_low,
    output logic cp_ok,
    output logic whol_ok
);
    localparam int MAXV = (CP_CYC > WHOL_CYC) ? CP_CYC : WHOL_CYC;
    localparam int W    = $clog2(MAXV + 1) + 1;

    logic [W-1:0] hi_cnt;
    logic [W-1:0] wgap;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            wgap   <= W'(WHOL_CYC);
        end else begin
            if (!deselected)
                hi_cnt <= '0;
            else if (hi_cnt < W'(CP_CYC))
                hi_cnt <= hi_cnt + 1'b1;

            if (strobe_low)
                wgap <= '0;
            else if (wgap < W'(WHOL_CYC))
                wgap <= wgap + 1'b1;
        end
    end

    // Select falls one cycle after acceptance, so one cycle is already spent.
    assign cp_ok   = (int'(hi_cnt) + 1 >= CP_CYC);
    assign whol_ok = (int'(wgap) >= WHOL_CYC);

endmodule

// File: rtl/psram_burst_budget.sv
module psram_burst_budget #(
    parameter int BURST_CYC = 400,
    parameter int PRC_CYC   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic selected,
    output logic page_room
);
    localparam int W = $clog2(BURST_CYC + 1);

    logic [W-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst || !selected)
            bcnt <= '0;
        else if (bcnt < W'(BURST_CYC))
            bcnt <= bcnt + 1'b1;
    end

    // One more page access plus the closing cycle must fit under the limit.
    assign page_room = (int'(bcnt) + PRC_CYC + 3 < BURST_CYC);

endmodule

// File: rtl/psram_lane_ctrl.sv
module psram_lane_ctrl (
    input  logic       active,
    input  logic [1:0] be,
    output logic       lb_n,
    output logic       ub_n
);
    logic both;

    always_comb begin
        both = (be == 2'b00);
        lb_n = !(active && (be[0] || both));
        ub_n = !(active && (be[1] || both));
    end

endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
    import psram_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int T_RC_NS    = 65,
    parameter int T_PRC_NS   = 20,
    parameter int T_WP_NS    = 40,
    parameter int T_CP_NS    = 12,
    parameter int T_WHOL_NS  = 25,
    parameter int T_BURST_NS = 4000,
    parameter int T_OEHI_NS  = 1000,
    parameter int HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int RC_CYC    = ns2cyc(T_RC_NS, CLK_NS);
    localparam int PRC_CYC   = ns2cyc(T_PRC_NS, CLK_NS);
    localparam int WP_CYC    = ns2cyc(T_WP_NS, CLK_NS);
    localparam int CP_CYC    = ns2cyc(T_CP_NS, CLK_NS);
    localparam int WHOL_CYC  = ns2cyc(T_WHOL_NS, CLK_NS);
    localparam int BURST_CYC = ns2cyc(T_BURST_NS, CLK_NS);
    localparam int OEHI_CYC  = ns2cyc(T_OEHI_NS, CLK_NS);
    localparam int CNT_W     = $clog2(RC_CYC + WP_CYC + HOLD_CYC + 1);

    pstate_e           st;
    logic [CNT_W-1:0]  cnt;
    preq_t             cur;
    logic              cp_ok, whol_ok, page_room;
    logic              same_page, accept, dq_drive, rd_state;

    psram_gap_tracker #(.CP_CYC(CP_CYC), .WHOL_CYC(WHOL_CYC)) u_gap (
        .clk(clk), .rst(rst),
        .deselected(st == ST_IDLE),
        .strobe_low(st == ST_WR_PULSE),
        .cp_ok(cp_ok), .whol_ok(whol_ok)
    );

    psram_burst_budget #(.BURST_CYC(BURST_CYC), .PRC_CYC(PRC_CYC)) u_budget (
        .clk(clk), .rst(rst),
        .selected(st != ST_IDLE),
        .page_room(page_room)
    );

    psram_lane_ctrl u_lanes (
        .active(st != ST_IDLE), .be(cur.be),
        .lb_n(mem_lb_n), .ub_n(mem_ub_n)
    );

    assign same_page = (req_addr[ADDR_W-1:PAGE_BITS] == cur.addr[ADDR_W-1:PAGE_BITS]);

    always_comb begin
        case (st)
            ST_IDLE:    req_ready = cp_ok && (req_we || whol_ok);
            ST_RD_OPEN: req_ready = req_valid && !req_we && same_page && page_room;
            default:    req_ready = 1'b0;
        endcase
    end

    assign accept   = req_valid && req_ready;
    assign rd_state = (st == ST_RD_ACC) || (st == ST_RD_OPEN) || (st == ST_RD_PAGE);
    assign dq_drive = (st == ST_WR_PULSE) || (st == ST_WR_HOLD);

    assign mem_cs_n = (st == ST_IDLE);
    assign mem_oe_n = !rd_state;
    assign mem_we_n = (st != ST_WR_PULSE);
    assign mem_addr = cur.addr;
    assign mem_dq   = dq_drive ? cur.wdata : {DATA_W{1'bz}};

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            cur       <= '{addr: '0, be: 2'b11, wdata: '0};
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        cur <= '{addr: req_addr, be: req_be, wdata: req_wdata};
                        cnt <= '0;
                        st  <= req_we ? ST_WR_PULSE : ST_RD_ACC;
                    end
                end
                ST_RD_ACC, ST_RD_PAGE: begin
                    if ((st == ST_RD_ACC  && cnt == CNT_W'(RC_CYC - 1)) ||
                        (st == ST_RD_PAGE && cnt == CNT_W'(PRC_CYC - 1))) begin
                        rsp_rdata <= mem_dq & lane_mask(cur.be);
                        rsp_valid <= 1'b1;
                        st        <= ST_RD_OPEN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RD_OPEN: begin
                    if (accept) begin
                        cur.addr <= req_addr;
                        cur.be   <= req_be;
                        cnt      <= '0;
                        st       <= ST_RD_PAGE;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_WR_PULSE: begin
                    if (cnt == CNT_W'(WP_CYC - 1)) begin
                        cnt <= '0;
                        st  <= ST_WR_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WR_HOLD: begin
                    if (cnt == CNT_W'(HOLD_CYC - 1))
                        st <= ST_IDLE;
                    else
                        cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/psram_page_ctrl_chk.sv
module psram_page_ctrl_chk
    import psram_pkg::*;
#(
    parameter int WP_CYC    = 4,
    parameter int CP_CYC    = 2,
    parameter int WHOL_CYC  = 3,
    parameter int BURST_CYC = 400,
    parameter int OEHI_CYC  = 100
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             oe_n,
    input logic             we_n,
    input logic             lb_n,
    input logic             ub_n,
    input logic [TAG_W-1:0] addr_hi,
    input logic             dq_drive,
    input logic             req_ready,
    input logic             rsp_valid
);
    logic [15:0] hi_run, lo_run, wl_run, wh_run, oeh_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run  <= '0;
            lo_run  <= '0;
            wl_run  <= '0;
            wh_run  <= 16'(WHOL_CYC);
            oeh_run <= '0;
        end else begin
            hi_run  <= cs_n ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
            lo_run  <= !cs_n ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1) : '0;
            wl_run  <= !we_n ? ((wl_run == 16'hFFFF) ? wl_run : wl_run + 1'b1) : '0;
            wh_run  <= we_n ? ((wh_run == 16'hFFFF) ? wh_run : wh_run + 1'b1) : '0;
            oeh_run <= (!cs_n && oe_n) ? ((oeh_run == 16'hFFFF) ? oeh_run : oeh_run + 1'b1) : '0;
        end
    end

    AST_PAGE_TAG_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> (addr_hi == $past(addr_hi))); // R3
    AST_CS_HIGH_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (int'(hi_run) >= CP_CYC)); // R8
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (int'(wl_run) >= WP_CYC)); // R7
    AST_STROBE_BUS: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (oe_n && dq_drive)); // R7
    AST_BUS_NO_FIGHT: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> oe_n); // R7
    AST_WE_TO_OE: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> (int'(wh_run) >= WHOL_CYC)); // R9
    AST_SELECT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (int'(lo_run) < BURST_CYC)); // R5
    AST_OE_HIGH_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && oe_n) |-> (int'(oeh_run) < OEHI_CYC)); // R10
    AST_LANE_PRESENT: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> !(lb_n && ub_n)); // R6
    AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !req_ready); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R2
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (oe_n && we_n && lb_n && ub_n)); // R1

endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(
    .WP_CYC(WP_CYC), .CP_CYC(CP_CYC), .WHOL_CYC(WHOL_CYC),
    .BURST_CYC(BURST_CYC), .OEHI_CYC(OEHI_CYC)
) u_chk (
    .clk(clk), .rst(rst), .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .lb_n(mem_lb_n), .ub_n(mem_ub_n),
    .addr_hi(mem_addr[psram_pkg::ADDR_W-1:psram_pkg::PAGE_BITS]),
    .dq_drive(dq_drive), .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/psram_page_ctrl_bench.sv
`timescale 1ns/1ps
module psram_page_ctrl_bench;
    localparam int CLK = 10;
    localparam int RC = (65 + CLK - 1) / CLK;
    localparam int PRC = (20 + CLK - 1) / CLK;
    localparam int WP = (40 + CLK - 1) / CLK;
    localparam int CP = (12 + CLK - 1) / CLK;
    localparam int WHOL = (25 + CLK - 1) / CLK;
    localparam int BURST = (4000 + CLK - 1) / CLK;
    localparam int OEHI = (1000 + CLK - 1) / CLK;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic req_ready, rsp_valid;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0, rsp_rdata;
    logic mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [21:0] mem_addr;
    wire  [15:0] mem_dq;

    always #(CLK/2) clk = ~clk;

    psram_page_ctrl u_psram_page_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] bmask(input logic [1:0] be);
        return (be == 2'b00) ? 16'hFFFF : {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // ---------------- memory model ----------------
    logic [15:0] mem [64];
    logic [15:0] shadow [64];
    int   age = 0;
    bit   full_acc = 1, prev_low = 0;
    logic [21:0] last_addr = '0;
    int   wl = 0;
    logic [15:0] wbuf = '0;
    logic [5:0]  widx = '0;
    bit   wlo = 0, wup = 0;
    logic [15:0] model_rd;

    always_comb begin
        if (prev_low && mem_addr == last_addr && age >= (full_acc ? RC : PRC) - 1)
            model_rd = mem[mem_addr[5:0]];
        else
            model_rd = 16'hBAD0;
    end
    assign mem_dq = (!mem_cs_n && !mem_oe_n) ? model_rd : 16'hzzzz;

    always @(posedge clk) begin
        if (mem_cs_n) begin
            prev_low <= 0;
            age <= 0;
        end else if (!prev_low || mem_addr != last_addr) begin
            full_acc <= !prev_low || (mem_addr[21:3] != last_addr[21:3]);
            prev_low <= 1;
            age <= 1;
        end else if (age < 1000) begin
            age <= age + 1;
        end
        last_addr <= mem_addr;
        if (!mem_cs_n && !mem_we_n) begin
            wl <= wl + 1;
            wbuf <= mem_dq;
            widx <= mem_addr[5:0];
            wlo <= !mem_lb_n;
            wup <= !mem_ub_n;
        end else begin
            if (wl >= WP) begin
                if (wlo) mem[widx][7:0]  <= wbuf[7:0];
                if (wup) mem[widx][15:8] <= wbuf[15:8];
            end
            wl <= 0;
        end
    end

    // ---------------- pin monitors (sampled at negedge) ----------------
    int hi_run = 0, lo_run = 0, wlr = 0, whr = 1000, oehr = 0;
    int min_hi = 1000, max_lo = 0, min_wl = 1000, min_gap = 1000, max_oeh = 0;
    int cs_rises = 0, busy_ready = 0, dq_bad = 0;
    bit pcs = 1, poe = 1;
    logic [15:0] cur_wdata = '0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc_dummy_guard();
            if (mem_cs_n) begin
                if (!pcs) cs_rises++;
                hi_run++; lo_run = 0;
            end else begin
                if (pcs && hi_run < min_hi) min_hi = hi_run;
                hi_run = 0; lo_run++;
                if (lo_run > max_lo) max_lo = lo_run;
            end
            if (!mem_we_n) begin
                wlr++; whr = 0;
                if (mem_dq !== cur_wdata) dq_bad++;
                if (req_ready) busy_ready++;
            end else begin
                if (wlr > 0 && wlr < min_wl) min_wl = wlr;
                wlr = 0; whr++;
            end
            if (!mem_oe_n && poe && whr - 1 < min_gap) min_gap = whr - 1;
            if (!mem_cs_n && mem_oe_n) begin
                oehr++;
                if (oehr > max_oeh) max_oeh = oehr;
            end else oehr = 0;
            pcs = mem_cs_n; poe = mem_oe_n;
        end
    end

    task automatic cyc_dummy_guard();
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- request / response ----------------
    logic [15:0] exp_d[$];
    int exp_lat[$], acc_cyc[$];
    string exp_tag[$];

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_d.size() == 0) begin
                chk(0, "R11 unexpected response", int'(rsp_rdata), 0);
            end else begin
                logic [15:0] d;
                int l, a;
                string t;
                d = exp_d.pop_front(); l = exp_lat.pop_front();
                a = acc_cyc.pop_front(); t = exp_tag.pop_front();
                chk(rsp_rdata == d, {t, " read data"}, int'(rsp_rdata), int'(d));
                chk(cyc - a == l, {t, " read latency"}, cyc - a, l);
            end
        end
    end

    task automatic send(input bit we, input logic [21:0] a, input logic [1:0] be,
                        input logic [15:0] d, input string tag);
        bit page;
        @(negedge clk);
        req_valid = 1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
        while (!req_ready) @(negedge clk);
        page = !mem_cs_n;
        if (we) cur_wdata = d;
        @(posedge clk);
        #1;
        if (we) begin
            if (be == 2'b00 || be[0]) shadow[a[5:0]][7:0]  = d[7:0];
            if (be == 2'b00 || be[1]) shadow[a[5:0]][15:8] = d[15:8];
        end else begin
            exp_d.push_back(shadow[a[5:0]] & bmask(be));
            exp_lat.push_back(page ? PRC : RC);
            acc_cyc.push_back(cyc);
            exp_tag.push_back(tag);
        end
    endtask

    task automatic drain();
        @(negedge clk);
        req_valid = 0;
        while (exp_d.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [21:0] waddr(input int i, input int tagv);
        return {16'(tagv), 6'(i)};
    endfunction

    initial begin
        int r0;
        for (int i = 0; i < 64; i++) begin mem[i] = '0; shadow[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: pins idle in reset
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 control pins in reset",
            {mem_cs_n, mem_oe_n, mem_we_n}, 7);
        chk(mem_lb_n && mem_ub_n && !rsp_valid, "R1 lanes and strobe in reset",
            {mem_lb_n, mem_ub_n, rsp_valid}, 6);
        rst = 0;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !rsp_valid,
            "R1 idle after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 31);

        // R7: full-word writes of every model location
        for (int i = 0; i < 64; i++)
            send(1, waddr(i, 16'h2A5 + i), 2'b11, 16'(i * 16'h1357) ^ 16'hC3A5, "R7");
        drain();

        // R2: random-order single reads
        for (int k = 0; k < 64; k++) begin
            int idx;
            idx = (k * 37) % 64;
            send(0, waddr(idx, 16'h300 + k), 2'b11, '0, "R2");
        end
        drain();

        // R3/R6: page bursts with every lane pattern
        for (int p = 0; p < 8; p++) begin
            r0 = cs_rises;
            for (int w = 0; w < 8; w++)
                send(0, waddr(p * 8 + (w * 3) % 8, 16'h0F0 + p), 2'(w % 4), '0, "R3 R6");
            drain();
            chk(cs_rises - r0 == 1, "R3 select held across page burst", cs_rises - r0, 1);
        end

        // R6: single-lane writes, then full-word read back
        for (int i = 0; i < 16; i++)
            send(1, waddr(i * 4, 16'h111), 2'(1 + (i % 2)), 16'hA5A5 ^ 16'(i * 16'h0F1E), "R6");
        send(1, waddr(63, 16'h111), 2'b00, 16'h6C93, "R6");
        for (int i = 0; i < 16; i++) send(0, waddr(i * 4, 16'h111), 2'b11, '0, "R6");
        send(0, waddr(63, 16'h111), 2'b11, '0, "R6");
        drain();

        // R4: page change and write interrupt a burst
        r0 = cs_rises;
        send(0, waddr(16, 16'h050), 2'b11, '0, "R4");
        send(0, waddr(40, 16'h051), 2'b11, '0, "R4");
        send(1, waddr(41, 16'h051), 2'b11, 16'h1234, "R4");
        send(0, waddr(41, 16'h051), 2'b11, '0, "R4");
        drain();
        chk(cs_rises - r0 == 4, "R4 burst closed per request", cs_rises - r0, 4);

        // R5: long same-page stream must be broken up
        r0 = cs_rises;
        for (int k = 0; k < 180; k++) send(0, waddr(8 + (k % 8), 16'h077), 2'b11, '0, "R5");
        drain();
        chk(cs_rises - r0 >= 2, "R5 burst forcibly closed", cs_rises - r0, 2);
        chk(max_lo < BURST, "R5 select low run", max_lo, BURST - 1);

        // Pin timing summaries
        chk(min_wl >= WP, "R7 strobe width", min_wl, WP);
        chk(dq_bad == 0, "R7 bus data during strobe", dq_bad, 0);
        chk(min_hi >= CP, "R8 select high gap", min_hi, CP);
        chk(min_gap >= WHOL, "R9 strobe to output enable gap", min_gap, WHOL);
        chk(max_oeh < OEHI, "R10 selected with output disabled", max_oeh, OEHI - 1);
        chk(busy_ready == 0, "R11 ready during strobe", busy_ready, 0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule